// File: doc/BRIEF.md
# Store Queue with Read-Miss Forwarding

This block sits between a write-through cache and the next memory level. Every store the cache performs, together with any store that misses and goes around the cache under a no-write-allocate policy, is presented on one write port. The store is queued in a small first-in-first-out store. Queued stores drain toward memory one at a time, oldest first, under a valid/ready handshake. The writer waits only when it presents a store while every slot is occupied and no slot is freed in that same cycle.

When the cache misses on a read, the requested word address is compared against all pending entries in the same cycle. If one or more entries match, the data of the most recently queued match is returned at once and no memory read is issued. If nothing matches, no older store to that word is still pending, so the read is sent to memory in the same cycle. A store presented in the same cycle as a read is not part of that search; it becomes visible from the next cycle. An entry that is draining in the current cycle still counts as pending.

Occupancy is tracked by a three-state machine. `OCC_EMPTY` holds no entries. `OCC_PARTIAL` holds between one and DEPTH-1 entries. `OCC_FULL` holds DEPTH entries. The transitions are as follows. FILL_FIRST goes from `OCC_EMPTY` to `OCC_PARTIAL` on an accepted store. FILL_LAST goes from `OCC_PARTIAL` to `OCC_FULL` when a store is accepted at DEPTH-1 entries and nothing drains. DRAIN_LAST goes from `OCC_PARTIAL` to `OCC_EMPTY` when the last entry drains and no store is accepted. DRAIN_FULL goes from `OCC_FULL` to `OCC_PARTIAL` when an entry drains and no store is accepted. In every other case the state holds. DEPTH must be a power of two and at least 2.

Top module: `wbuf_top`

## Requirements
- R1: After reset the queue is empty: `mem_wvalid`, `wr_stall`, `rd_hit` and `mem_rvalid` are all 0.
- R2: A store with `wr_valid`=1 and `wr_stall`=0 is accepted at that clock edge. From the next cycle it is pending, so `mem_wvalid` is 1 whenever at least one entry is pending and 0 otherwise.
- R3: Entries leave in acceptance order, one per cycle with `mem_wvalid`=1 and `mem_wready`=1. `mem_waddr` and `mem_wdata` show the oldest pending entry and stay unchanged while `mem_wready` is 0.
- R4: `wr_stall` is 1 exactly when `wr_valid` is 1, DEPTH entries are pending and `mem_wready` is 0.
- R5: With DEPTH entries pending and `mem_wready`=1, a presented store is accepted without a stall in the same cycle as the drain.
- R6: With `rd_req`=1 and at least one pending entry whose address equals `rd_addr`, `rd_hit` is 1 in the same cycle and `rd_data` equals the data of the most recently accepted matching entry.
- R7: With `rd_req`=1 and no matching pending entry, `mem_rvalid` is 1 in the same cycle with `mem_raddr` equal to `rd_addr`, and `rd_hit` is 0. On a match, `mem_rvalid` is 0.
- R8: With `rd_req`=0, `rd_hit` and `mem_rvalid` are both 0.
- R9: A store presented in the same cycle as a read takes no part in that read's search. It matches from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Store presented by the cache |
| wr_addr | input | AW | Word address of the store |
| wr_data | input | DW | Store data |
| wr_stall | output | 1 | Store not accepted this cycle; hold it |
| rd_req | input | 1 | Read miss lookup request |
| rd_addr | input | AW | Word address of the read miss |
| rd_hit | output | 1 | A pending store supplies the read data |
| rd_data | output | DW | Forwarded data, 0 when no hit |
| mem_rvalid | output | 1 | Read miss sent on to memory |
| mem_raddr | output | AW | Address of the read sent to memory |
| mem_wvalid | output | 1 | Oldest entry offered to memory |
| mem_waddr | output | AW | Address of the offered entry |
| mem_wdata | output | DW | Data of the offered entry |
| mem_wready | input | 1 | Memory takes the offered entry this cycle |

## Verification
The stall, the hit, the forwarded data and the read forward are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs just after the falling edge and compares these outputs one time unit later, before the rising edge that acts on them. An accepted store or a drain changes the queue at the next rising edge. The bench's reference queue is therefore updated at that edge, and `mem_wvalid`, `mem_waddr` and `mem_wdata` are compared against it from the next cycle onward. Random traffic over a small address range forces repeated matches, and directed steps cover the full stall, the full-with-drain acceptance and the same-cycle store and read.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // Occupancy of the store queue
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             mem_wready,
    output logic             push,
    output logic             pop,
    output logic             wr_stall,
    output logic             mem_wvalid,
    output logic [CNT_W-1:0] occ
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] occ_q, occ_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            occ_q   <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
        end
    end

    // Outputs
    always_comb begin
        mem_wvalid = 1'b0;
        wr_stall   = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin
                mem_wvalid = 1'b0;
                wr_stall   = 1'b0;
            end
            OCC_PARTIAL: begin
                mem_wvalid = 1'b1;
                wr_stall   = 1'b0;
            end
            OCC_FULL: begin
                mem_wvalid = 1'b1;
                wr_stall   = wr_valid && !mem_wready;
            end
            default: begin
                mem_wvalid = 1'b0;
                wr_stall   = 1'b0;
            end
        endcase
        push = wr_valid && !wr_stall;
        pop  = mem_wvalid && mem_wready;
        occ  = occ_q;
    end

    // Next state
    always_comb begin
        unique case ({push, pop})
            2'b10:   occ_d = occ_q + ONE;
            2'b01:   occ_d = occ_q - ONE;
            default: occ_d = occ_q;
        endcase

        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push) state_d = OCC_PARTIAL;                           // FILL_FIRST
            end
            OCC_PARTIAL: begin
                if (push && !pop && occ_q == LAST)     state_d = OCC_FULL;  // FILL_LAST
                else if (pop && !push && occ_q == ONE) state_d = OCC_EMPTY; // DRAIN_LAST
            end
            OCC_FULL: begin
                if (pop && !push) state_d = OCC_PARTIAL;                   // DRAIN_FULL
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic                      pop,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    output logic [AW-1:0]             head_addr,
    output logic [DW-1:0]             head_data,
    output logic [DEPTH-1:0][AW-1:0]  slot_addr,
    output logic [DEPTH-1:0][DW-1:0]  slot_data,
    output logic [PTR_W-1:0]          rd_ptr
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

    logic [PTR_W-1:0] wr_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + STEP;
            if (pop)  rd_ptr <= rd_ptr + STEP;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(g)) begin
                slot_addr[g] <= wr_addr;
                slot_data[g] <= wr_data;
            end
        end
    end

    assign head_addr = slot_addr[rd_ptr];
    assign head_data = slot_data[rd_ptr];

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0]             rd_addr,
    input  logic [DEPTH-1:0][AW-1:0]  slot_addr,
    input  logic [DEPTH-1:0][DW-1:0]  slot_data,
    input  logic [PTR_W-1:0]          rd_ptr,
    input  logic [CNT_W-1:0]          occ,
    output logic                      hit,
    output logic [DW-1:0]             hit_data
);

    logic [DEPTH-1:0][PTR_W-1:0] slot_of;
    logic [DEPTH-1:0]            age_ok;

    // One comparator per age position, age 0 being the oldest entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign slot_of[g] = rd_ptr + PTR_W'(g);
        assign age_ok[g]  = (CNT_W'(g) < occ) && (slot_addr[slot_of[g]] == rd_addr);
    end

    // Younger matches override older ones
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (age_ok[k]) begin
                hit      = 1'b1;
                hit_data = slot_data[slot_of[k]];
            end
        end
    end

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_stall,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_hit,
    output logic [DW-1:0] rd_data,
    output logic          mem_rvalid,
    output logic [AW-1:0] mem_raddr,
    output logic          mem_wvalid,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_wready
);

    logic                     push;
    logic                     pop;
    logic [CNT_W-1:0]         occ;
    logic [PTR_W-1:0]         rd_ptr;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][DW-1:0] slot_data;
    logic                     match_hit;
    logic [DW-1:0]            match_data;

    wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .mem_wready (mem_wready),
        .push       (push),
        .pop        (pop),
        .wr_stall   (wr_stall),
        .mem_wvalid (mem_wvalid),
        .occ        (occ)
    );

    wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .head_addr (mem_waddr),
        .head_data (mem_wdata),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .rd_ptr    (rd_ptr)
    );

    wbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .rd_addr   (rd_addr),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .rd_ptr    (rd_ptr),
        .occ       (occ),
        .hit       (match_hit),
        .hit_data  (match_data)
    );

    assign rd_hit     = rd_req && match_hit;
    assign rd_data    = rd_hit ? match_data : '0;
    assign mem_rvalid = rd_req && !match_hit;
    assign mem_raddr  = rd_addr;

endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             wr_stall,
    input logic             rd_req,
    input logic             rd_hit,
    input logic             mem_rvalid,
    input logic             mem_wvalid,
    input logic [AW-1:0]    mem_waddr,
    input logic [DW-1:0]    mem_wdata,
    input logic             mem_wready,
    input logic [CNT_W-1:0] occ
);

    // R4
    stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |-> (wr_valid && occ == CNT_W'(DEPTH) && !mem_wready));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R3
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

    // R7
    hit_or_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_hit != mem_rvalid));

    // R8
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> (!rd_hit && !mem_rvalid));

    // R2
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (!mem_wvalid && !rd_hit));

endmodule

bind wbuf_top wbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_stall   (wr_stall),
    .rd_req     (rd_req),
    .rd_hit     (rd_hit),
    .mem_rvalid (mem_rvalid),
    .mem_wvalid (mem_wvalid),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_wready (mem_wready),
    .occ        (occ)
);

// File: tb/wbuf_top_bench.sv
module wbuf_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_stall;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_hit;
    logic [DW-1:0] rd_data;
    logic          mem_rvalid;
    logic [AW-1:0] mem_raddr;
    logic          mem_wvalid;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic          mem_wready = 1'b0;

    int checks = 0;
    int fails  = 0;

    // Reference queue
    logic [AW-1:0] qa [64];
    logic [DW-1:0] qd [64];
    int qh = 0;
    int qn = 0;

    wbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_wbuf_top (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
        .mem_rvalid(mem_rvalid), .mem_raddr(mem_raddr),
        .mem_wvalid(mem_wvalid), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_wready(mem_wready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_full();
        return qn == DEPTH;
    endfunction

    // Newest matching pending entry; returns 1 on a hit
    function automatic bit model_lookup(logic [AW-1:0] a, output logic [DW-1:0] d);
        d = '0;
        for (int k = qn - 1; k >= 0; k--) begin
            if (qa[(qh + k) % 64] == a) begin
                d = qd[(qh + k) % 64];
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    // One cycle: drive after the falling edge, compare, then follow the rising edge
    task automatic step(bit wv, logic [AW-1:0] wa, logic [DW-1:0] wd,
                        bit rr, logic [AW-1:0] ra, bit wrdy);
        bit            exp_stall;
        bit            exp_hit;
        logic [DW-1:0] exp_data;
        wr_valid   = wv;
        wr_addr    = wa;
        wr_data    = wd;
        rd_req     = rr;
        rd_addr    = ra;
        mem_wready = wrdy;
        #1;
        exp_stall = wv && model_full() && !wrdy;
        exp_hit   = model_lookup(ra, exp_data);
        if (wv && model_full() && wrdy)
            check("R5 stall while draining", 64'(wr_stall), 64'(0));
        else
            check("R4 stall", 64'(wr_stall), 64'(exp_stall));
        check("R2 mem_wvalid", 64'(mem_wvalid), 64'(qn > 0));
        if (qn > 0) begin
            check("R3 head addr", 64'(mem_waddr), 64'(qa[qh]));
            check("R3 head data", 64'(mem_wdata), 64'(qd[qh]));
        end
        if (!rr) begin
            check("R8 rd_hit idle", 64'(rd_hit), 64'(0));
            check("R8 mem_rvalid idle", 64'(mem_rvalid), 64'(0));
        end else begin
            check("R6 rd_hit", 64'(rd_hit), 64'(exp_hit));
            if (exp_hit) check("R6 rd_data newest", 64'(rd_data), 64'(exp_data));
            check("R7 mem_rvalid", 64'(mem_rvalid), 64'(!exp_hit));
            if (!exp_hit) check("R7 mem_raddr", 64'(mem_raddr), 64'(ra));
        end
        @(posedge clk);
        if (qn > 0 && wrdy) begin
            qh = (qh + 1) % 64;
            qn--;
        end
        if (wv && !exp_stall) begin
            qa[(qh + qn) % 64] = wa;
            qd[(qh + qn) % 64] = wd;
            qn++;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [DW-1:0] dummy;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state, during and after reset
        #1;
        check("R1 mem_wvalid in reset", 64'(mem_wvalid), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        wr_valid = 1'b1;
        rd_req   = 1'b1;
        #1;
        check("R1 wr_stall", 64'(wr_stall), 64'(0));
        check("R1 rd_hit", 64'(rd_hit), 64'(0));
        check("R1 mem_wvalid", 64'(mem_wvalid), 64'(0));
        wr_valid = 1'b0;
        rd_req   = 1'b0;
        @(negedge clk);

        // Directed: fill while memory is busy
        step(1, 16'd3, 32'hA1, 0, 16'd0, 0);
        step(1, 16'd5, 32'hB1, 1, 16'd3, 0);
        step(1, 16'd3, 32'hA2, 0, 16'd0, 0);
        step(1, 16'd7, 32'hC1, 1, 16'd3, 0);   // R6 newest of two matches
        step(1, 16'd9, 32'hD1, 1, 16'd9, 0);   // R4 stall at full, R7 miss forwarded
        check("R4 queue still full", 64'(qn), 64'(DEPTH));
        step(1, 16'd9, 32'hD1, 1, 16'd5, 1);   // R5 accepted while draining
        repeat (5) step(0, 16'd0, 32'h0, 1, 16'd9, 1);
        void'(model_lookup(16'd0, dummy));
        // R9: store and read to the same word in one cycle
        step(1, 16'd11, 32'hE1, 1, 16'd11, 0);
        step(0, 16'd0, 32'h0, 1, 16'd11, 0);    // R9 visible one cycle later
        repeat (3) step(0, 16'd0, 32'h0, 0, 16'd0, 1);

        // Random traffic over a small address range
        for (int i = 0; i < 3000; i++) begin
            bit busy_phase;
            busy_phase = ((i / 200) % 2) == 1;
            step(($urandom % 3) != 0, AW'($urandom % 8), $urandom,
                 ($urandom % 2) == 1, AW'($urandom % 8),
                 busy_phase ? (($urandom % 4) == 0) : (($urandom % 4) != 0));
        end
        finish_run();
    end

endmodule